// File: doc/BRIEF.md
# Banked Register File Decoder

This block is the register file of a small 8-bit controller core, together with its address decoder and its access guard. An access gives either a plain 8-bit register number or, through the E0h–EFh codes, a working-register number. A working-register number is moved into the group chosen by the upper nibble of a register pointer. Each access reads or writes one byte, or an aligned pair of bytes as a 16-bit word.

The array holds registers 00h–DFh. A resolved address in F0h–FFh is passed out on a small bus to the peripheral control registers. A resolved address in E0h–EFh has no storage behind it.

A guard can close the upper register area to all traffic. The guard is switched by bit 6 of the interrupt-mask value, and that bit may change at any time. The guard checks the address after working-register relocation, so relocation cannot be used to get around it. A blocked access reports a violation pulse. Register contents are never initialised: stored values are kept across a reset.

Top module: `regf_bank`

## Requirements
- R1: A byte write to a direct address in 00h–DFh stores `wdata_i[7:0]` in that register, and a later byte read of the same address returns it on `rdata_o[7:0]` with `rdata_o[15:8]` = 00h.
- R2: A direct address {Eh, n} refers to physical register {`rp_i[7:4]`, n}; data written this way can be read back through the direct physical address.
- R3: A pair access at even address A maps bits 15:8 to register A and bits 7:0 to register A+1, for both writes and reads.
- R4: A pair access with address bit 0 = 1 raises `pair_err_o` while it is active, writes nothing and reads 0000h.
- R5: When `imask_i[6]` = 1, a read whose resolved address lies in 80h–EFh returns 0000h, and a write there leaves the register unchanged.
- R6: `prot_viol_o` is 1 in exactly the cycle after a clock edge that sampled a blocked access, and is 0 during and after reset otherwise.
- R7: When `imask_i[6]` = 0, registers 80h–DFh read and write normally, and the bit may be toggled between accesses.
- R8: Protection is decided on the resolved address, so a working-register access whose pointer selects group 8h–Dh is blocked when the guard is on.
- R9: A resolved address {Fh, k} drives `ctl_sel_o`, `ctl_addr_o` = k, and `ctl_we_o` / `ctl_wdata_o` for writes. A byte read from it returns `ctl_rdata_i`. The array is not touched, and a pair access there is a pair error.
- R10: A resolved address in E0h–EFh (pointer upper nibble Eh) reads 0000h and ignores writes.
- R11: A reset pulse does not alter stored register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Active-low reset of the violation flag only |
| acc_rd_i | input | 1 | Read access strobe |
| acc_wr_i | input | 1 | Write access strobe |
| pair_i | input | 1 | 1 = 16-bit pair access, 0 = byte |
| addr_i | input | 8 | Direct address or {Eh, working number} |
| rp_i | input | 8 | Register pointer; bits 7:4 pick the working group |
| imask_i | input | 8 | Interrupt-mask value; bit 6 turns on the guard |
| wdata_i | input | 16 | Write data (byte uses bits 7:0) |
| rdata_o | output | 16 | Combinational read data |
| pair_err_o | output | 1 | Misaligned or control-area pair access |
| prot_viol_o | output | 1 | One-cycle flag after a blocked access |
| ctl_sel_o | output | 1 | Control-register access select |
| ctl_we_o | output | 1 | Control-register write strobe |
| ctl_addr_o | output | 4 | Control-register index |
| ctl_wdata_o | output | 8 | Control-register write data |
| ctl_rdata_i | input | 8 | Control-register read data |

## Verification
A wrong relocation or a wrong protect decision shows on `rdata_o` in the same cycle the address is driven, because reads are combinational. A lost or misdirected write shows up only at the first later read of the affected register, so every write in the stimulus is followed by a read-back through a different address form where one exists. A stuck or missing violation flag shows one edge after the offending access. A write that leaks into the array from a blocked or control-area access shows only when that register is read back. For this reason the stimulus reads back every register a suppressed write could have hit.

// File: rtl/regf_pkg.sv
package regf_pkg;
   // classification of a resolved physical address
   typedef enum logic [1:0] {
      AREA_STORE = 2'd0,
      AREA_VOID  = 2'd1,
      AREA_CTRL  = 2'd2
   } area_e;

   localparam logic [3:0] WREG_PAGE = 4'hE;
   localparam logic [3:0] CTRL_PAGE = 4'hF;
endpackage

// File: rtl/regf_resolve.sv
module regf_resolve
   import regf_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] rp_i,
   output logic [AW-1:0] phys_o,
   output area_e         area_o
);
   localparam int PW = 4;
   localparam int LW = AW - PW;

   initial assert (AW == 8) else $error("regf_resolve: AW must be 8");

   logic [PW-1:0] page_in, page_out;

   assign page_in = addr_i[AW-1 -: PW];

   always_comb begin
      if (page_in == WREG_PAGE) phys_o = {rp_i[AW-1 -: PW], addr_i[LW-1:0]};
      else                      phys_o = addr_i;
   end

   assign page_out = phys_o[AW-1 -: PW];

   always_comb begin
      unique case (page_out)
         CTRL_PAGE: area_o = AREA_CTRL;
         WREG_PAGE: area_o = AREA_VOID;
         default:   area_o = AREA_STORE;
      endcase
   end
endmodule

// File: rtl/regf_guard.sv
module regf_guard
   import regf_pkg::*;
#(
   parameter int          AW         = 8,
   parameter int          IMW        = 8,
   parameter int          PROT_BIT   = 6,
   parameter bit          PROTECT_EN = 1'b1,
   parameter logic [7:0]  PROT_LO    = 8'h80,
   parameter logic [7:0]  PROT_HI    = 8'hEF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rd_i,
   input  logic           wr_i,
   input  logic           pair_i,
   input  logic [AW-1:0]  phys_i,
   input  area_e          area_i,
   input  logic [IMW-1:0] imask_i,
   output logic           ok_o,
   output logic           pair_err_o,
   output logic           viol_o
);
   initial assert (PROT_BIT < IMW) else $error("regf_guard: PROT_BIT out of range");
   initial assert (PROT_LO <= PROT_HI) else $error("regf_guard: empty window");

   logic prot_on, in_window, blocked, misalign, viol_q;

   generate
      if (PROTECT_EN) begin : g_prot
         assign prot_on = imask_i[PROT_BIT];
      end else begin : g_noprot
         assign prot_on = 1'b0;
      end
   endgenerate

   assign in_window = (phys_i >= AW'(PROT_LO)) && (phys_i <= AW'(PROT_HI))
                      && (area_i != AREA_CTRL);
   assign blocked   = prot_on && in_window;
   assign misalign  = pair_i && (phys_i[0] || (area_i == AREA_CTRL));
   assign ok_o       = !blocked && !misalign;
   assign pair_err_o = (rd_i || wr_i) && misalign;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) viol_q <= 1'b0;
      else        viol_q <= (rd_i || wr_i) && blocked && !misalign;
   end
   assign viol_o = viol_q;

   // R6
   viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> $past(rd_i || wr_i));
endmodule

// File: rtl/regf_store.sv
module regf_store #(
   parameter int AW    = 8,
   parameter int DW    = 8,
   parameter int DEPTH = 224
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic          pair_i,
   input  logic [AW-1:0] addr_i,
   input  logic [2*DW-1:0] wdata_i,
   output logic [DW-1:0] hi_o,
   output logic [DW-1:0] lo_o
);
   initial assert (DEPTH <= (1 << AW)) else $error("regf_store: DEPTH too large");
   initial assert (DEPTH % 2 == 0) else $error("regf_store: DEPTH must be even");

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] odd_addr;

   assign odd_addr = addr_i | AW'(1);

   always_ff @(posedge clk) begin
      if (we_i) begin
         if (pair_i) begin
            mem[addr_i]   <= wdata_i[2*DW-1:DW];
            mem[odd_addr] <= wdata_i[DW-1:0];
         end else begin
            mem[addr_i]   <= wdata_i[DW-1:0];
         end
      end
   end

   assign hi_o = (int'(addr_i)   < DEPTH) ? mem[addr_i]   : '0;
   assign lo_o = (int'(odd_addr) < DEPTH) ? mem[odd_addr] : '0;

   // R10
   store_range_chk: assert property (@(posedge clk)
      we_i |-> (int'(addr_i) < DEPTH));
endmodule

// File: rtl/regf_bank.sv
module regf_bank
   import regf_pkg::*;
#(
   parameter int         AW         = 8,
   parameter int         DW         = 8,
   parameter int         IMW        = 8,
   parameter int         PROT_BIT   = 6,
   parameter bit         PROTECT_EN = 1'b1,
   parameter logic [7:0] PROT_LO    = 8'h80,
   parameter logic [7:0] PROT_HI    = 8'hEF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_rd_i,
   input  logic            acc_wr_i,
   input  logic            pair_i,
   input  logic [AW-1:0]   addr_i,
   input  logic [AW-1:0]   rp_i,
   input  logic [IMW-1:0]  imask_i,
   input  logic [2*DW-1:0] wdata_i,
   output logic [2*DW-1:0] rdata_o,
   output logic            pair_err_o,
   output logic            prot_viol_o,
   output logic            ctl_sel_o,
   output logic            ctl_we_o,
   output logic [3:0]      ctl_addr_o,
   output logic [DW-1:0]   ctl_wdata_o,
   input  logic [DW-1:0]   ctl_rdata_i
);
   localparam int DEPTH = (1 << AW) - 32;

   initial assert (DW >= 1) else $error("regf_bank: DW must be positive");

   logic [AW-1:0] phys;
   area_e         area;
   logic          ok, store_we;
   logic [DW-1:0] hi_byte, lo_byte;

   regf_resolve #(.AW(AW)) u_resolve (
      .addr_i (addr_i),
      .rp_i   (rp_i),
      .phys_o (phys),
      .area_o (area)
   );

   regf_guard #(
      .AW(AW), .IMW(IMW), .PROT_BIT(PROT_BIT), .PROTECT_EN(PROTECT_EN),
      .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
   ) u_guard (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_i       (acc_rd_i),
      .wr_i       (acc_wr_i),
      .pair_i     (pair_i),
      .phys_i     (phys),
      .area_i     (area),
      .imask_i    (imask_i),
      .ok_o       (ok),
      .pair_err_o (pair_err_o),
      .viol_o     (prot_viol_o)
   );

   assign store_we = acc_wr_i && ok && (area == AREA_STORE);

   regf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .we_i    (store_we),
      .pair_i  (pair_i),
      .addr_i  (phys),
      .wdata_i (wdata_i),
      .hi_o    (hi_byte),
      .lo_o    (lo_byte)
   );

   assign ctl_sel_o   = (acc_rd_i || acc_wr_i) && ok && (area == AREA_CTRL);
   assign ctl_we_o    = ctl_sel_o && acc_wr_i;
   assign ctl_addr_o  = phys[3:0];
   assign ctl_wdata_o = wdata_i[DW-1:0];

   always_comb begin
      rdata_o = '0;
      if (ok) begin
         unique case (area)
            AREA_STORE: rdata_o = pair_i ? {hi_byte, lo_byte} : {{DW{1'b0}}, hi_byte};
            AREA_CTRL:  rdata_o = {{DW{1'b0}}, ctl_rdata_i};
            default:    rdata_o = '0;
         endcase
      end
   end

   // R4
   pair_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_err_o |-> (!store_we && !ctl_sel_o));

   // R9
   ctl_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we_o |-> !store_we);

   // R5
   prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (imask_i[PROT_BIT] && PROTECT_EN && acc_wr_i && phys >= AW'(PROT_LO)
       && phys <= AW'(PROT_HI)) |-> !store_we);

   // R5
   prot_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (imask_i[PROT_BIT] && PROTECT_EN && acc_rd_i && phys >= AW'(PROT_LO)
       && phys <= AW'(PROT_HI)) |-> (rdata_o == '0));
endmodule

// File: tb/regf_bank_test.sv
`timescale 1ns/1ps
module regf_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_rd = 1'b0, acc_wr = 1'b0, pair = 1'b0;
   logic [7:0]  addr = '0, rp = '0, imask = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        pair_err, prot_viol, ctl_sel, ctl_we;
   logic [3:0]  ctl_addr;
   logic [7:0]  ctl_wdata;
   logic [7:0]  ctl_rdata = 8'hA5;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   regf_bank uut (
      .clk(clk), .rst_n(rst_n), .acc_rd_i(acc_rd), .acc_wr_i(acc_wr),
      .pair_i(pair), .addr_i(addr), .rp_i(rp), .imask_i(imask),
      .wdata_i(wdata), .rdata_o(rdata), .pair_err_o(pair_err),
      .prot_viol_o(prot_viol), .ctl_sel_o(ctl_sel), .ctl_we_o(ctl_we),
      .ctl_addr_o(ctl_addr), .ctl_wdata_o(ctl_wdata), .ctl_rdata_i(ctl_rdata)
   );

   typedef struct packed {
      logic        wr;
      logic        pr;
      logic [7:0]  a;
      logic [7:0]  p;
      logic        prot;
      logic [15:0] wd;
      logic [15:0] exp;
      logic        viol;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b0, 8'h12, 8'h00, 1'b0, 16'h003C, 16'h0000, 1'b0}, // R1 write
      '{1'b0, 1'b0, 8'h12, 8'h00, 1'b0, 16'h0000, 16'h003C, 1'b0}, // R1 read
      '{1'b1, 1'b1, 8'h40, 8'h00, 1'b0, 16'hBEEF, 16'h0000, 1'b0}, // R3 pair write
      '{1'b0, 1'b0, 8'h40, 8'h00, 1'b0, 16'h0000, 16'h00BE, 1'b0}, // R3 high byte
      '{1'b0, 1'b0, 8'h41, 8'h00, 1'b0, 16'h0000, 16'h00EF, 1'b0}, // R3 low byte
      '{1'b0, 1'b1, 8'h40, 8'h00, 1'b0, 16'h0000, 16'hBEEF, 1'b0}, // R3 pair read
      '{1'b1, 1'b0, 8'hE5, 8'h30, 1'b0, 16'h0077, 16'h0000, 1'b0}, // R2 working write
      '{1'b0, 1'b0, 8'h35, 8'h00, 1'b0, 16'h0000, 16'h0077, 1'b0}, // R2 direct readback
      '{1'b1, 1'b0, 8'h90, 8'h00, 1'b0, 16'h005A, 16'h0000, 1'b0}, // R7 open write
      '{1'b0, 1'b0, 8'h90, 8'h00, 1'b0, 16'h0000, 16'h005A, 1'b0}, // R7 open read
      '{1'b0, 1'b0, 8'h90, 8'h00, 1'b1, 16'h0000, 16'h0000, 1'b1}, // R5 R6 blocked read
      '{1'b1, 1'b0, 8'h90, 8'h00, 1'b1, 16'h0011, 16'h0000, 1'b1}, // R5 blocked write
      '{1'b0, 1'b0, 8'h90, 8'h00, 1'b0, 16'h0000, 16'h005A, 1'b0}, // R5 R7 unchanged
      '{1'b0, 1'b0, 8'hE0, 8'h90, 1'b1, 16'h0000, 16'h0000, 1'b1}, // R8 relocated blocked
      '{1'b0, 1'b0, 8'hE0, 8'h90, 1'b0, 16'h0000, 16'h005A, 1'b0}  // R8 relocated open
   };

   logic [15:0] s_rd;
   logic        s_err, s_viol, s_sel, s_we;
   logic [3:0]  s_ca;
   logic [7:0]  s_cw;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic acc(input bit w, input bit p, input logic [7:0] a, input logic [7:0] r,
                      input bit prot, input logic [15:0] wd);
      @(negedge clk);
      acc_wr = w; acc_rd = !w; pair = p; addr = a; rp = r;
      imask = {1'b0, prot, 6'b0}; wdata = wd;
      #5;
      s_rd = rdata; s_err = pair_err; s_sel = ctl_sel; s_we = ctl_we;
      s_ca = ctl_addr; s_cw = ctl_wdata;
      @(posedge clk);
      #2;
      s_viol = prot_viol;
      acc_wr = 1'b0; acc_rd = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R6 reset flag low", {15'b0, prot_viol}, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         acc(VEC[i].wr, VEC[i].pr, VEC[i].a, VEC[i].p, VEC[i].prot, VEC[i].wd);
         if (!VEC[i].wr) check($sformatf("vector %0d rdata", i), s_rd, VEC[i].exp);
         check($sformatf("vector %0d flag R6", i), {15'b0, s_viol}, {15'b0, VEC[i].viol});
      end

      // R6 flag lasts a single cycle after a blocked access
      acc(1'b0, 1'b0, 8'h90, 8'h00, 1'b1, 16'h0);
      acc(1'b0, 1'b0, 8'h12, 8'h00, 1'b1, 16'h0);
      check("R6 flag drops", {15'b0, s_viol}, 16'h0000);
      check("R7 low area open with guard on", s_rd, 16'h003C);

      // R4 misaligned pair
      acc(1'b1, 1'b1, 8'h42, 8'h00, 1'b0, 16'hABCD);
      acc(1'b1, 1'b1, 8'h43, 8'h00, 1'b0, 16'h1234);
      check("R4 error flag", {15'b0, s_err}, 16'h0001);
      acc(1'b0, 1'b1, 8'h43, 8'h00, 1'b0, 16'h0);
      check("R4 misaligned read zero", s_rd, 16'h0000);
      acc(1'b0, 1'b1, 8'h42, 8'h00, 1'b0, 16'h0);
      check("R4 no write", s_rd, 16'hABCD);
      check("R4 aligned no error", {15'b0, s_err}, 16'h0000);

      // R9 control pass-through
      acc(1'b1, 1'b0, 8'hF3, 8'h00, 1'b1, 16'h00C7);
      check("R9 select/write", {14'b0, s_sel, s_we}, 16'h0003);
      check("R9 index/data", {4'b0, s_ca, s_cw}, 16'h03C7);
      acc(1'b0, 1'b0, 8'hE6, 8'hF0, 1'b0, 16'h0);
      check("R9 read via working", s_rd, 16'h00A5);
      check("R9 index via working", {12'b0, s_ca}, 16'h0006);
      acc(1'b1, 1'b1, 8'hF0, 8'h00, 1'b0, 16'h1111);
      check("R9 pair error", {15'b0, s_err}, 16'h0001);
      check("R9 pair no strobe", {14'b0, s_sel, s_we}, 16'h0000);

      // R10 void group
      acc(1'b1, 1'b0, 8'hE4, 8'hE0, 1'b0, 16'h0099);
      acc(1'b0, 1'b0, 8'hE4, 8'hE0, 1'b0, 16'h0);
      check("R10 void reads zero", s_rd, 16'h0000);
      acc(1'b0, 1'b0, 8'h12, 8'h00, 1'b0, 16'h0);
      check("R10 no stray write", s_rd, 16'h003C);

      // R11 contents kept over reset
      acc(1'b1, 1'b0, 8'h20, 8'h00, 1'b0, 16'h00C3);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      acc(1'b0, 1'b0, 8'h20, 8'h00, 1'b0, 16'h0);
      check("R11 survives reset", s_rd, 16'h00C3);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule